// File: doc/BRIEF.md
# Multi-Framer Spare-Bit and Timeslot Control Register Bank

This block is the processor-side register store for eight identical E1 framer instances. A 12-bit address carries a framer-select code in its top four bits and a register offset in its low byte. Codes 0 to 7 pick one framer. Code 8 is a broadcast code: a write with it lands in the addressed register of every framer in the same clock edge. Codes 9 to 15 reach nothing.

Each framer owns two kinds of register. The first is a group of five national-bit bytes at offsets 0x40 to 0x44, one per spare bit position Sa4 to Sa8. Each byte is not a single setting. It is spread over an eight-frame group, one bit per frame. The second is a table of 32 per-timeslot control bytes at offsets 0x80 to 0x9F. Bit 0 of each control byte is unused. The entry for timeslot 0 is held at zero.

Every framer presents a frame-within-group index and a timeslot index. The bank returns that framer's five spare bits for the current frame and the control byte for the requested timeslot. Reads go through a one-cycle registered read port.

Top module: `nbb_top`

## Requirements
- R1: A write with select code f in 0..7 changes only framer f. No other framer's outputs or read-back contents change.
- R2: A write with select code 8 stores the same data into the addressed register of all eight framers on the same edge.
- R3: Writes with select codes 9..15 change nothing. Reads with codes 9..15 return 0x00. A read with code 8 returns framer 0's contents.
- R4: The national-bit bytes sit at offsets 0x40..0x44, in the order Sa4, Sa5, Sa6, Sa7, Sa8. After reset each of them reads 0xFF.
- R5: Output sa_bits[f*5+j] equals bit k of framer f's national-bit byte j, where k is frm_idx[f*3+:3]. Bit 0 serves the first frame of the eight-frame group. The output follows the index combinationally.
- R6: The timeslot control byte for timeslot n sits at offset 0x80+n. All of these bytes reset to 0x00. Bit 0 is unused and always reads 0.
- R7: Writes to the timeslot 0 control byte are ignored. That byte always reads 0x00 and is always presented as 0x00.
- R8: Data for a read strobe appears on rd_data one cycle later. rd_data holds its value while rd_en is low. Offsets that are not mapped read 0x00. A read and a write to the same register in the same cycle return the old contents.
- R9: Output ts_ctrl[f*8+:8] equals framer f's control byte for timeslot ts_idx[f*5+:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | [11:8] framer select, [7:0] register offset |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| frm_idx | input | 24 | Per-framer frame-within-group index, 3 bits each |
| ts_idx | input | 40 | Per-framer timeslot index, 5 bits each |
| sa_bits | output | 40 | Per-framer Sa4..Sa8 bits for the current frame, 5 bits each |
| ts_ctrl | output | 64 | Per-framer control byte of the selected timeslot, 8 bits each |

## Verification
A read strobe sampled at a rising edge produces its data on rd_data after that same edge, so the result is due one cycle after the strobe. The spare-bit and control-byte outputs change in two ways: right after the edge that accepts a write, and in the same cycle that a framer's index changes. The bench drives inputs on the falling edge and updates its reference model at each rising edge. It then compares every output against the model on the next falling edge, so each result is checked in the cycle it is due. Directed phases cover reset values, single-framer and broadcast writes, ignored select codes, the timeslot 0 entry, read-during-write and index sweeps. A long stretch of mixed random traffic follows them.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
  // width of the framer-select field at the top of the address
  localparam int SEL_W = 4;
  // offsets of the two register regions inside one framer
  localparam logic [7:0] NB_BASE = 8'h40;
  localparam logic [7:0] TS_BASE = 8'h80;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_NB   = 2'd1,
    RK_TS   = 2'd2
  } reg_kind_e;
endpackage

// File: rtl/nbb_decode.sv
module nbb_decode
  import nbb_pkg::*;
#(
  parameter int NF = 8,
  parameter int NB = 5,
  parameter int NT = 32,
  parameter int AW = 12,
  localparam int FSW = $clog2(NF),
  localparam int IW  = $clog2(NT)
) (
  input  logic [AW-1:0]  addr,
  output reg_kind_e      kind,
  output logic [IW-1:0]  idx,
  output logic [NF-1:0]  fr_hit,
  output logic [FSW-1:0] rd_fr,
  output logic           rd_zero
);
  logic [SEL_W-1:0] fsel;
  logic [7:0]       lo;
  logic [7:0]       nb_off;
  logic [7:0]       ts_off;

  assign fsel = addr[AW-1 -: SEL_W];
  assign lo   = addr[7:0];

  always_comb begin
    nb_off = lo - NB_BASE;
    ts_off = lo - TS_BASE;
    kind   = RK_NONE;
    idx    = '0;
    if (lo >= NB_BASE && nb_off < 8'(NB)) begin
      kind = RK_NB;
      idx  = nb_off[IW-1:0];
    end else if (lo >= TS_BASE && ts_off < 8'(NT)) begin
      kind = RK_TS;
      idx  = ts_off[IW-1:0];
    end
    // a framer is hit by its own code or by the broadcast code (== NF)
    for (int f = 0; f < NF; f++) begin
      fr_hit[f] = (fsel == SEL_W'(f)) || (fsel == SEL_W'(NF));
    end
    rd_zero = (fsel > SEL_W'(NF));
    rd_fr   = (fsel == SEL_W'(NF)) ? '0 : fsel[FSW-1:0];
  end
endmodule

// File: rtl/nbb_fr_store.sv
module nbb_fr_store
  import nbb_pkg::*;
#(
  parameter int NB = 5,
  parameter int NT = 32,
  parameter int DW = 8,
  localparam int IW   = $clog2(NT),
  localparam int NBI  = $clog2(NB),
  localparam int FI_W = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  reg_kind_e       kind,
  input  logic [IW-1:0]   idx,
  input  logic [DW-1:0]   wdata,
  input  logic [FI_W-1:0] frm_idx,
  input  logic [IW-1:0]   ts_idx,
  output logic [DW-1:0]   rd_val,
  output logic [NB-1:0]   sa_bits,
  output logic [DW-1:0]   ts_ctrl
);
  // national-bit bytes, one bit per frame of the group
  logic [NB-1:0][DW-1:0] nb_q, nb_d;
  // control bytes; bit 0 is not stored
  logic [NT-1:0][DW-1:1] ts_q, ts_d;

  always_comb begin
    nb_d = nb_q;
    ts_d = ts_q;
    for (int j = 0; j < NB; j++) begin
      if (kind == RK_NB && idx == IW'(j)) nb_d[j] = wdata;
    end
    for (int t = 1; t < NT; t++) begin
      if (kind == RK_TS && idx == IW'(t)) ts_d[t] = wdata[DW-1:1];
    end
    ts_d[0] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb_q <= '1;
      ts_q <= '0;
    end else if (we) begin
      nb_q <= nb_d;
      ts_q <= ts_d;
    end
  end

  always_comb begin
    for (int j = 0; j < NB; j++) sa_bits[j] = nb_q[j][frm_idx];
    ts_ctrl = {ts_q[ts_idx], 1'b0};
    unique case (kind)
      RK_NB:   rd_val = nb_q[idx[NBI-1:0]];
      RK_TS:   rd_val = {ts_q[idx], 1'b0};
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/nbb_top.sv
module nbb_top
  import nbb_pkg::*;
#(
  parameter int NF = 8,
  parameter int NB = 5,
  parameter int NT = 32,
  parameter int DW = 8,
  parameter int AW = 12,
  localparam int FSW  = $clog2(NF),
  localparam int IW   = $clog2(NT),
  localparam int FI_W = $clog2(DW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rd_data,
  input  logic [NF*FI_W-1:0] frm_idx,
  input  logic [NF*IW-1:0]   ts_idx,
  output logic [NF*NB-1:0]   sa_bits,
  output logic [NF*DW-1:0]   ts_ctrl
);
  reg_kind_e             kind;
  logic [IW-1:0]         idx;
  logic [NF-1:0]         fr_hit;
  logic [FSW-1:0]        rd_fr;
  logic                  rd_zero;
  logic [NF-1:0][DW-1:0] rd_val;
  logic [DW-1:0]         rd_q, rd_nxt;

  nbb_decode #(.NF(NF), .NB(NB), .NT(NT), .AW(AW)) u_dec (
    .addr    (addr),
    .kind    (kind),
    .idx     (idx),
    .fr_hit  (fr_hit),
    .rd_fr   (rd_fr),
    .rd_zero (rd_zero)
  );

  for (genvar f = 0; f < NF; f++) begin : g_fr
    nbb_fr_store #(.NB(NB), .NT(NT), .DW(DW)) u_st (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en & fr_hit[f]),
      .kind    (kind),
      .idx     (idx),
      .wdata   (wdata),
      .frm_idx (frm_idx[f*FI_W +: FI_W]),
      .ts_idx  (ts_idx[f*IW +: IW]),
      .rd_val  (rd_val[f]),
      .sa_bits (sa_bits[f*NB +: NB]),
      .ts_ctrl (ts_ctrl[f*DW +: DW])
    );
  end

  // read sampled before this edge's write: old contents are returned
  always_comb begin
    rd_nxt = rd_zero ? '0 : rd_val[rd_fr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_en) rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/nbb_chk.sv
module nbb_chk
  import nbb_pkg::*;
#(
  parameter int NF = 8,
  parameter int NB = 5,
  parameter int NT = 32,
  parameter int DW = 8,
  parameter int AW = 12,
  localparam int IW   = $clog2(NT),
  localparam int FI_W = $clog2(DW)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [AW-1:0]      addr,
  input logic [DW-1:0]      wdata,
  input logic [DW-1:0]      rd_data,
  input logic [NF*FI_W-1:0] frm_idx,
  input logic [NF*IW-1:0]   ts_idx,
  input logic [NF*NB-1:0]   sa_bits,
  input logic [NF*DW-1:0]   ts_ctrl
);
  logic [SEL_W-1:0] fsel;
  assign fsel = addr[AW-1 -: SEL_W];

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R3
  rd_void_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && fsel > SEL_W'(NF) |=> rd_data == '0);

  // R3
  wr_void_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && fsel > SEL_W'(NF) |=>
      (!$stable(frm_idx) || !$stable(ts_idx) || ($stable(sa_bits) && $stable(ts_ctrl))));

  for (genvar f = 0; f < NF; f++) begin : g_chk
    // R7
    ts_zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_idx[f*IW +: IW] == '0 |-> ts_ctrl[f*DW +: DW] == '0);

    // R6
    ts_unused_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_ctrl[f*DW] == 1'b0);

    // R1
    other_framer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && fsel < SEL_W'(NF) && fsel != SEL_W'(f) |=>
        (!$stable(frm_idx[f*FI_W +: FI_W]) || !$stable(ts_idx[f*IW +: IW]) ||
         ($stable(sa_bits[f*NB +: NB]) && $stable(ts_ctrl[f*DW +: DW]))));

    // R2
    bcast_sa4_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && fsel == SEL_W'(NF) && addr[7:0] == NB_BASE |=>
        (!$stable(frm_idx[f*FI_W +: FI_W]) ||
         sa_bits[f*NB] == $past(wdata[frm_idx[f*FI_W +: FI_W]])));
  end
endmodule

bind nbb_top nbb_chk #(.NF(NF), .NB(NB), .NT(NT), .DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rd_data (rd_data),
  .frm_idx (frm_idx),
  .ts_idx  (ts_idx),
  .sa_bits (sa_bits),
  .ts_ctrl (ts_ctrl)
);

// File: tb/nbb_top_tb.sv
`timescale 1ns/1ps
module nbb_top_tb;
  localparam int NF = 8, NB = 5, NT = 32, DW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [7:0]  wdata, rd_data;
  logic [23:0] frm_idx;
  logic [39:0] ts_idx;
  logic [39:0] sa_bits;
  logic [63:0] ts_ctrl;

  always #2 clk = ~clk;

  nbb_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .frm_idx(frm_idx), .ts_idx(ts_idx),
    .sa_bits(sa_bits), .ts_ctrl(ts_ctrl)
  );

  int n_chk = 0, n_fail = 0;
  string ph = "R4";
  logic [7:0] m_nb [8][5];
  logic [7:0] m_ts [8][32];
  logic [7:0] m_rd;

  function automatic logic [7:0] mread(logic [11:0] a);
    int fs = int'(a[11:8]);
    int lo = int'(a[7:0]);
    int f;
    if (fs > 8) return 8'h00;
    f = (fs == 8) ? 0 : fs;
    if (lo >= 'h40 && lo < 'h45) return m_nb[f][lo - 'h40];
    if (lo >= 'h80 && lo < 'hA0) return m_ts[f][lo - 'h80];
    return 8'h00;
  endfunction

  task automatic mwrite(logic [11:0] a, logic [7:0] d);
    int fs = int'(a[11:8]);
    int lo = int'(a[7:0]);
    for (int f = 0; f < 8; f++) begin
      if (fs == f || fs == 8) begin
        if (lo >= 'h40 && lo < 'h45) m_nb[f][lo - 'h40] = d;
        if (lo > 'h80 && lo < 'hA0) m_ts[f][lo - 'h80] = d & 8'hFE;
      end
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < 8; f++) begin
        for (int j = 0; j < 5; j++) m_nb[f][j] = 8'hFF;
        for (int t = 0; t < 32; t++) m_ts[f][t] = 8'h00;
      end
      m_rd = 8'h00;
    end else begin
      if (rd_en) m_rd = mread(addr);
      if (wr_en) mwrite(addr, wdata);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(ph, "rd_data", int'(rd_data), int'(m_rd));
    for (int f = 0; f < 8; f++) begin
      for (int j = 0; j < 5; j++)
        chk("R5", $sformatf("sa_bits f%0d j%0d", f, j), int'(sa_bits[f*5+j]),
            int'(m_nb[f][j][frm_idx[f*3 +: 3]]));
      chk("R9", $sformatf("ts_ctrl f%0d", f), int'(ts_ctrl[f*8 +: 8]),
          int'(m_ts[f][ts_idx[f*5 +: 5]]));
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a);
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    frm_idx = '0; ts_idx = '0;
    repeat (3) step();
    rst_n = 1'b1;

    // R4 R6: reset contents seen through reads
    ph = "R4";
    for (int j = 0; j < 5; j++) rd(12'h340 + 12'(j));
    ph = "R6";
    rd(12'h585); rd(12'h09F);

    // R1: single framer writes
    ph = "R1";
    wr(12'h342, 8'h5A); rd(12'h342); rd(12'h242); rd(12'h442);
    wr(12'h785, 8'hFF); rd(12'h785); rd(12'h685);
    ts_idx = {8{5'd5}}; step();
    frm_idx = {8{3'd1}}; step();

    // R2: broadcast
    ph = "R2";
    wr(12'h840, 8'hA5);
    for (int f = 0; f < 8; f++) rd({4'(f), 8'h40});
    wr(12'h89F, 8'hC3);
    ts_idx = {8{5'd31}}; step();

    // R3: void select codes
    ph = "R3";
    for (int fs = 9; fs < 16; fs++) wr({4'(fs), 8'h41}, 8'h00);
    for (int fs = 9; fs < 16; fs++) rd({4'(fs), 8'h41});
    rd(12'h840); rd(12'h89F);

    // R7: timeslot 0 entry
    ph = "R7";
    ts_idx = '0;
    wr(12'h080, 8'hFF); wr(12'h880, 8'hAB); rd(12'h080); rd(12'h880);

    // R8: hold, unmapped offsets, read during write
    ph = "R8";
    rd(12'h240); repeat (3) step();
    rd(12'h245); rd(12'h27F); rd(12'h2A0);
    wr_en = 1'b1; rd_en = 1'b1; addr = 12'h143; wdata = 8'h3C; step();
    wr_en = 1'b0; rd_en = 1'b0; rd(12'h143);

    // R5: frame index sweep over a known pattern
    ph = "R5";
    wr(12'h844, 8'b1001_0110);
    for (int k = 0; k < 8; k++) begin
      frm_idx = {8{3'(k)}}; step();
    end

    // R9: timeslot index sweep
    ph = "R9";
    for (int t = 0; t < 32; t++) wr({4'(t % 8), 8'h80 + 8'(t)}, 8'(t * 7 + 3));
    for (int t = 0; t < 32; t++) begin
      ts_idx = {8{5'(t)}}; step();
    end

    // mixed traffic
    ph = "R8";
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] lo;
      int sel = int'($urandom_range(0, 3));
      lo = (sel == 0) ? 8'h40 + 8'($urandom_range(0, 5)) :
           (sel == 1) ? 8'h80 + 8'($urandom_range(0, 31)) :
           (sel == 2) ? 8'h80 : 8'($urandom);
      wr_en = 1'($urandom); rd_en = 1'($urandom);
      addr = {4'($urandom_range(0, 15)), lo};
      wdata = 8'($urandom);
      frm_idx = 24'($urandom); ts_idx = {8'($urandom), 32'($urandom)};
      step();
    end
    wr_en = 1'b0; rd_en = 1'b0;
    step();

    summary();
    $finish;
  end
endmodule